// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer with Sleep Handling

This block is the digital side of a 10-bit successive-approximation analog-to-digital converter in a microcontroller. Software reaches it through a small byte-wide write port. A control register holds the converter enable, a start bit that also reads back as busy, a conversion clock source select, an alignment select, an interrupt enable and a completion flag. Two result bytes hold the converted value. The block drives a trial code to an external comparator and resolves one result bit per conversion clock, most significant bit first. It then places the 10-bit value in the 16-bit result pair, aligned to the left or to the right, with the six spare positions zeroed.

A sleep input reports that the surrounding device has gone to sleep. What happens then depends on the selected conversion clock. With the free-running internal oscillator source (select 2'b11), a conversion already under way runs to the end. On completion the block either raises its wake/interrupt output or powers the converter down. With any divided system-clock source, sleep aborts the conversion and powers the converter down. In every case the enable bit stays set, and a separate powered status output shows the power-down. Power returns when sleep ends. A reset stops the sequencer and clears the control register. The result bytes keep their contents across a reset and are undefined only at power-up.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With the alignment bit (control bit 4) at 0, a result v is stored as high byte = v[9:2] and low byte = {v[1:0], 6'b0}.
- R2: With the alignment bit at 1, a result v is stored as high byte = {6'b0, v[9:8]} and low byte = v[7:0].
- R3: With enable (control bit 0) at 0, bus writes to address 1 (high byte) and address 2 (low byte) load the written byte. With enable at 1, such writes leave both bytes unchanged.
- R4: With clock select (control bits 3:2) at 0, 1 or 2, the system clock is divided by DIV0, DIV1 or DIV2. The busy bit stays high for exactly 10 × divisor clock cycles after the start write. The stored result is the code the comparator input resolves MSB first (comparator 1 means the input is at or above the trial code).
- R5: With clock select 2'b11, the block waits INSTR_CYC clock cycles after the start write and then resolves one bit per rc_tick pulse. With rc_tick held high, busy lasts INSTR_CYC + 10 cycles.
- R6: A completed conversion clears busy, loads the result bytes and sets the flag (control bit 6). irq_wake is high while the flag and the interrupt enable (control bit 5) are both 1. Writing 0 to bit 6 clears the flag.
- R7: With select 2'b11 and sleep_req high, a conversion completes normally. With the interrupt enabled, irq_wake rises and conv_pwr stays 1. With it disabled, conv_pwr falls to 0 after completion while enable stays 1.
- R8: With a select other than 2'b11 and sleep_req high during a conversion, busy is 0 one cycle later, conv_pwr is 0 and enable stays 1. The result bytes and the flag are unchanged. The abort wins when it falls in the same cycle as the final bit.
- R9: Once sleep_req is low, conv_pwr returns to 1 on the next cycle while enable is 1.
- R10: A reset clears enable, busy, select, alignment, interrupt enable, flag, conv_pwr and irq_wake, and aborts any conversion. The result bytes keep their values.
- R11: A start write (control bit 1 = 1) begins a conversion only when idle with conv_pwr at 1. A start write while busy does not restart the conversion, and one while powered down is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 result high, 2 result low |
| wr_data | input | 8 | Write data |
| sleep_req | input | 1 | High while the device is asleep |
| rc_tick | input | 1 | One-cycle pulse per internal oscillator period |
| cmp_in | input | 1 | Comparator: 1 when input is at or above dac_code |
| dac_code | output | NBITS | Trial code to the analog front end |
| res_hi | output | 8 | Result high byte |
| res_lo | output | 8 | Result low byte |
| ctl_en | output | 1 | Enable bit |
| ctl_go | output | 1 | Start/busy bit |
| ctl_cs | output | 2 | Conversion clock select |
| ctl_fmt | output | 1 | Alignment select |
| ctl_ie | output | 1 | Interrupt enable |
| ctl_flag | output | 1 | Completion flag |
| conv_pwr | output | 1 | Converter powered status |
| irq_wake | output | 1 | Interrupt/wake request |

## Verification
The sleep-driven abort and the final bit resolution can meet in one cycle. Only one of them can win: a loaded result with the flag set, or an untouched pair with the flag clear. The bench raises sleep_req with a divided source half a cycle before the tenth bit edge, a point it derives from the start write and the divisor. It then checks that the earlier result bytes remain, that the flag stays clear and that the converter is unpowered. A second overlap is a start write that arrives while busy. Here the busy-cycle count must still equal ten divisor periods.

// File: rtl/adc_pkg.sv
package adc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DELAY, ST_CONV} seq_st_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_LO   = 2'd2;
  localparam logic [1:0] CS_RC     = 2'b11;

  localparam int B_EN   = 0;
  localparam int B_GO   = 1;
  localparam int B_CS   = 2;
  localparam int B_FMT  = 4;
  localparam int B_IE   = 5;
  localparam int B_FLAG = 6;

  typedef struct packed {
    logic       flag;
    logic       ie;
    logic       fmt;
    logic [1:0] cs;
    logic       en;
  } ctl_t;
endpackage

// File: rtl/adc_clkgen.sv
module adc_clkgen #(
  parameter int DIV0 = 2,
  parameter int DIV1 = 4,
  parameter int DIV2 = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] cs,
  input  logic       rc_tick,
  output logic       tick
);
  localparam int DMAX = (DIV0 > DIV1) ? ((DIV0 > DIV2) ? DIV0 : DIV2)
                                      : ((DIV1 > DIV2) ? DIV1 : DIV2);
  localparam int CW = $clog2(DMAX + 1);
  localparam int DIVS [3] = '{DIV0, DIV1, DIV2};

  logic [CW-1:0] cnt_q, cnt_d;
  logic [3:0]    hit;

  genvar g;
  generate
    for (g = 0; g < 3; g++) begin : g_div
      assign hit[g] = (cnt_q == CW'(DIVS[g] - 1));
    end
  endgenerate
  assign hit[3] = rc_tick;

  assign tick = run & hit[cs];

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_sar.sv
module adc_sar #(
  parameter int NBITS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             cmp_in,
  output logic [NBITS-1:0] dac_code,
  output logic [NBITS-1:0] value,
  output logic             last
);
  localparam int IW = $clog2(NBITS);

  logic [NBITS-1:0] bits_q, bits_d, onehot;
  logic [IW-1:0]    idx_q, idx_d;

  assign onehot   = NBITS'(1) << idx_q;
  assign dac_code = bits_q | onehot;
  assign value    = cmp_in ? (bits_q | onehot) : bits_q;
  assign last     = tick && (idx_q == '0);

  always_comb begin
    bits_d = bits_q;
    idx_d  = idx_q;
    if (clr) begin
      bits_d = '0;
      idx_d  = IW'(NBITS - 1);
    end else if (tick) begin
      bits_d = value;
      if (idx_q != '0) idx_d = idx_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      idx_q  <= IW'(NBITS - 1);
    end else begin
      bits_q <= bits_d;
      idx_q  <= idx_d;
    end
  end
endmodule

// File: rtl/adc_result.sv
module adc_result #(
  parameter int NBITS = 10
) (
  input  logic             clk,
  input  logic             load,
  input  logic             fmt,
  input  logic [NBITS-1:0] value,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic [7:0]       wr_data,
  output logic [7:0]       res_hi,
  output logic [7:0]       res_lo
);
  localparam int PAD = 16 - NBITS;

  logic [15:0] left_w, right_w, word_w;
  logic [7:0]  hi_d, lo_d, hi_q, lo_q;

  assign left_w  = {value, {PAD{1'b0}}};
  assign right_w = {{PAD{1'b0}}, value};
  assign word_w  = fmt ? right_w : left_w;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (load) begin
      hi_d = word_w[15:8];
      lo_d = word_w[7:0];
    end else begin
      if (wr_hi) hi_d = wr_data;
      if (wr_lo) lo_d = wr_data;
    end
  end

  // result bytes deliberately carry no reset: they survive any reset
  always_ff @(posedge clk) begin
    hi_q <= hi_d;
    lo_q <= lo_d;
  end

  assign res_hi = hi_q;
  assign res_lo = lo_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_pkg::*;
#(
  parameter int NBITS     = 10,
  parameter int DIV0      = 2,
  parameter int DIV1      = 4,
  parameter int DIV2      = 8,
  parameter int INSTR_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             sleep_req,
  input  logic             rc_tick,
  input  logic             cmp_in,
  output logic [NBITS-1:0] dac_code,
  output logic [7:0]       res_hi,
  output logic [7:0]       res_lo,
  output logic             ctl_en,
  output logic             ctl_go,
  output logic [1:0]       ctl_cs,
  output logic             ctl_fmt,
  output logic             ctl_ie,
  output logic             ctl_flag,
  output logic             conv_pwr,
  output logic             irq_wake
);
  localparam int DW = $clog2(INSTR_CYC + 1);

  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  seq_st_t       st_q, st_d;
  ctl_t          ctl_q, ctl_d;
  logic          pdown_q, pdown_d;
  logic [DW-1:0] dcnt_q, dcnt_d;

  logic ctrl_wr, busy, rc_sel, kill, start, done;
  logic tick, sar_last;
  logic [NBITS-1:0] sar_value;

  assign ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
  assign rc_sel   = (ctl_q.cs == CS_RC);
  assign busy     = (st_q != ST_IDLE);
  assign conv_pwr = ctl_q.en && !pdown_q;
  assign kill     = busy && ((sleep_req && !rc_sel) || !ctl_q.en);
  assign start    = ctrl_wr && wr_data[B_GO] && !busy && conv_pwr;
  assign done     = sar_last && !kill;

  always_comb begin
    st_d   = st_q;
    dcnt_d = dcnt_q;
    case (st_q)
      ST_IDLE: begin
        dcnt_d = '0;
        if (start)
          st_d = (wr_data[B_CS +: 2] == CS_RC) ? ST_DELAY : ST_CONV;
      end
      ST_DELAY: begin
        if (dcnt_q == DW'(INSTR_CYC - 1)) st_d = ST_CONV;
        else                              dcnt_d = dcnt_q + 1'b1;
      end
      ST_CONV: begin
        if (done) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    if (kill) st_d = ST_IDLE;
  end

  always_comb begin
    ctl_d = ctl_q;
    if (ctrl_wr) begin
      ctl_d.en   = wr_data[B_EN];
      ctl_d.cs   = wr_data[B_CS +: 2];
      ctl_d.fmt  = wr_data[B_FMT];
      ctl_d.ie   = wr_data[B_IE];
      ctl_d.flag = wr_data[B_FLAG];
    end
    if (done) ctl_d.flag = 1'b1;
  end

  assign pdown_d = sleep_req &&
                   (pdown_q || (!rc_sel && ctl_q.en) || (done && !ctl_q.ie));

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q    <= ST_IDLE;
      ctl_q   <= '0;
      pdown_q <= 1'b0;
      dcnt_q  <= '0;
    end else begin
      st_q    <= st_d;
      ctl_q   <= ctl_d;
      pdown_q <= pdown_d;
      dcnt_q  <= dcnt_d;
    end
  end

  adc_clkgen #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2)) u_clk (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (st_q == ST_CONV),
    .cs      (ctl_q.cs),
    .rc_tick (rc_tick),
    .tick    (tick)
  );

  adc_sar #(.NBITS(NBITS)) u_sar (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (st_q != ST_CONV),
    .tick     (tick),
    .cmp_in   (cmp_in),
    .dac_code (dac_code),
    .value    (sar_value),
    .last     (sar_last)
  );

  adc_result #(.NBITS(NBITS)) u_res (
    .clk     (clk),
    .load    (done),
    .fmt     (ctl_q.fmt),
    .value   (sar_value),
    .wr_hi   (wr_en && (wr_addr == ADDR_HI) && !ctl_q.en),
    .wr_lo   (wr_en && (wr_addr == ADDR_LO) && !ctl_q.en),
    .wr_data (wr_data),
    .res_hi  (res_hi),
    .res_lo  (res_lo)
  );

  assign ctl_en   = ctl_q.en;
  assign ctl_go   = busy;
  assign ctl_cs   = ctl_q.cs;
  assign ctl_fmt  = ctl_q.fmt;
  assign ctl_ie   = ctl_q.ie;
  assign ctl_flag = ctl_q.flag;
  assign irq_wake = ctl_q.flag && ctl_q.ie;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic       sleep_req,
  input logic [7:0] res_hi,
  input logic [7:0] res_lo,
  input logic       ctl_en,
  input logic       ctl_go,
  input logic [1:0] ctl_cs,
  input logic       ctl_fmt,
  input logic       ctl_flag,
  input logic       conv_pwr
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == 2'd0);

  AST_ABORT_NONRC: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_go && sleep_req && (ctl_cs != 2'b11)) |=> !ctl_go); // R8

  AST_RES_HELD_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable({res_hi, res_lo}) && $past(ctl_en)) |-> $fell(ctl_go)); // R3

  AST_ZERO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctl_go) && !$stable({res_hi, res_lo}))
      |-> (ctl_fmt ? (res_hi[7:2] == 6'd0) : (res_lo[5:0] == 6'd0))); // R1 R2

  AST_PWR_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_req && ctl_en && !ctrl_wr) |=> conv_pwr); // R9

  AST_EN_KEPT_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && ctl_en && !ctrl_wr) |=> ctl_en); // R7

  AST_START_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_go) |-> $past(conv_pwr)); // R11

  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctl_go) && $past(ctl_en) && !$past(sleep_req && (ctl_cs != 2'b11)))
      |-> ctl_flag); // R6
endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .sleep_req (sleep_req),
  .res_hi    (res_hi),
  .res_lo    (res_lo),
  .ctl_en    (ctl_en),
  .ctl_go    (ctl_go),
  .ctl_cs    (ctl_cs),
  .ctl_fmt   (ctl_fmt),
  .ctl_flag  (ctl_flag),
  .conv_pwr  (conv_pwr)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  localparam int CLK_PER = 10;
  localparam int DIV0 = 2, DIV1 = 4, DIV2 = 8, INSTR = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       sleep_req = 1'b0;
  logic       rc_tick = 1'b0;
  logic       rc_hold = 1'b0;
  logic [9:0] analog = 10'd0;
  logic       cmp_in;
  logic [9:0] dac_code;
  logic [7:0] res_hi, res_lo;
  logic       ctl_en, ctl_go, ctl_fmt, ctl_ie, ctl_flag, conv_pwr, irq_wake;
  logic [1:0] ctl_cs;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PER/2) clk = ~clk;
  assign cmp_in = (analog >= dac_code);

  adc_seq_ctrl #(.NBITS(10), .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2),
                 .INSTR_CYC(INSTR)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sleep_req(sleep_req), .rc_tick(rc_tick),
    .cmp_in(cmp_in), .dac_code(dac_code), .res_hi(res_hi), .res_lo(res_lo),
    .ctl_en(ctl_en), .ctl_go(ctl_go), .ctl_cs(ctl_cs), .ctl_fmt(ctl_fmt),
    .ctl_ie(ctl_ie), .ctl_flag(ctl_flag), .conv_pwr(conv_pwr),
    .irq_wake(irq_wake)
  );

  // {fmt, cs, analog, expected high byte, expected low byte}
  localparam logic [28:0] VEC [10] = '{
    {1'b0, 2'd0, 10'h3FF, 8'hFF, 8'hC0},
    {1'b1, 2'd1, 10'h3FF, 8'h03, 8'hFF},
    {1'b0, 2'd2, 10'h2A5, 8'hA9, 8'h40},
    {1'b1, 2'd3, 10'h2A5, 8'h02, 8'hA5},
    {1'b0, 2'd3, 10'h155, 8'h55, 8'h40},
    {1'b1, 2'd0, 10'h155, 8'h01, 8'h55},
    {1'b0, 2'd1, 10'h200, 8'h80, 8'h00},
    {1'b1, 2'd2, 10'h001, 8'h00, 8'h01},
    {1'b0, 2'd0, 10'h001, 8'h00, 8'h40},
    {1'b1, 2'd1, 10'h000, 8'h00, 8'h00}
  };

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = ph + 1;
      rc_tick = rc_hold || (ph % 3 == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input bit en, input bit go, input logic [1:0] cs,
                                    input bit fmt, input bit ie);
    return {2'b00, ie, fmt, cs, go, en};
  endfunction

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (ctl_go && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PER * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    logic [7:0] kh, kl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    chk({ctl_en, ctl_go, ctl_cs, ctl_fmt, ctl_ie, ctl_flag, conv_pwr, irq_wake} == 9'd0,
        "R10 reset state", {ctl_en, ctl_go, ctl_cs, ctl_fmt, ctl_ie, ctl_flag, conv_pwr, irq_wake}, 0);

    // R3 writable while disabled
    bus_wr(2'd1, 8'h5A);
    bus_wr(2'd2, 8'hC3);
    chk({res_hi, res_lo} == 16'h5AC3, "R3 write disabled", {res_hi, res_lo}, 16'h5AC3);

    // R1 R2 R4 R5 R6 vector table
    for (int i = 0; i < 10; i++) begin
      logic fmt_v; logic [1:0] cs_v; logic [15:0] exp_v;
      {fmt_v, cs_v, analog, exp_v} = VEC[i];
      bus_wr(2'd0, mk(1, 0, cs_v, fmt_v, 0));
      bus_wr(2'd0, mk(1, 1, cs_v, fmt_v, 0));
      wait_idle(n);
      chk({res_hi, res_lo} == exp_v, fmt_v ? "R2 right align" : "R1 left align",
          {res_hi, res_lo}, exp_v);
      chk(ctl_flag == 1'b1 && ctl_go == 1'b0, "R6 done flag", {ctl_go, ctl_flag}, 1);
    end

    // R3 ignored while enabled
    bus_wr(2'd0, mk(1, 0, 2'd0, 0, 0));
    kh = res_hi; kl = res_lo;
    bus_wr(2'd1, 8'h11);
    bus_wr(2'd2, 8'h22);
    chk({res_hi, res_lo} == {kh, kl}, "R3 write ignored", {res_hi, res_lo}, {kh, kl});

    // R4 latency for two divided sources
    analog = 10'h0F0;
    bus_wr(2'd0, mk(1, 1, 2'd0, 0, 0));
    wait_idle(n);
    chk(n == 10 * DIV0, "R4 latency div0", n, 10 * DIV0);
    chk({res_hi, res_lo} == 16'h3C00, "R4 sar value", {res_hi, res_lo}, 16'h3C00);
    bus_wr(2'd0, mk(1, 1, 2'd1, 0, 0));
    wait_idle(n);
    chk(n == 10 * DIV1, "R4 latency div1", n, 10 * DIV1);

    // R5 internal source start delay
    rc_hold = 1'b1;
    bus_wr(2'd0, mk(1, 1, 2'd3, 1, 0));
    wait_idle(n);
    chk(n == INSTR + 10, "R5 rc latency", n, INSTR + 10);
    chk({res_hi, res_lo} == 16'h00F0, "R5 rc value", {res_hi, res_lo}, 16'h00F0);
    rc_hold = 1'b0;

    // R6 interrupt output and flag clear
    bus_wr(2'd0, mk(1, 1, 2'd0, 1, 1));
    wait_idle(n);
    chk(irq_wake == 1'b1, "R6 irq set", irq_wake, 1);
    bus_wr(2'd0, mk(1, 0, 2'd0, 1, 1));
    chk(irq_wake == 1'b0 && ctl_flag == 1'b0, "R6 flag clear", {ctl_flag, irq_wake}, 0);

    // R7 sleep with internal source, interrupt enabled
    analog = 10'h2C3;
    bus_wr(2'd0, mk(1, 1, 2'd3, 1, 1));
    sleep_req = 1'b1;
    wait_idle(n);
    @(negedge clk);
    chk({res_hi, res_lo} == 16'h02C3, "R7 sleep result", {res_hi, res_lo}, 16'h02C3);
    chk(irq_wake && conv_pwr && ctl_en, "R7 wake ie", {irq_wake, conv_pwr, ctl_en}, 7);
    sleep_req = 1'b0;
    bus_wr(2'd0, mk(1, 0, 2'd3, 1, 0));

    // R7 sleep with internal source, interrupt disabled
    analog = 10'h1E1;
    bus_wr(2'd0, mk(1, 1, 2'd3, 1, 0));
    sleep_req = 1'b1;
    wait_idle(n);
    @(negedge clk);
    chk({res_hi, res_lo} == 16'h01E1, "R7 sleep result noie", {res_hi, res_lo}, 16'h01E1);
    chk(!conv_pwr && ctl_en && !irq_wake, "R7 power down", {irq_wake, conv_pwr, ctl_en}, 1);
    // R9 power returns
    sleep_req = 1'b0;
    @(negedge clk);
    chk(conv_pwr == 1'b1, "R9 power restore", conv_pwr, 1);

    // R8 abort with divided source
    bus_wr(2'd0, mk(1, 0, 2'd1, 0, 0));
    kh = res_hi; kl = res_lo;
    analog = 10'h3AA;
    bus_wr(2'd0, mk(1, 1, 2'd1, 0, 0));
    repeat (4) @(negedge clk);
    sleep_req = 1'b1;
    @(negedge clk);
    chk(!ctl_go && !conv_pwr && ctl_en, "R8 abort", {ctl_go, conv_pwr, ctl_en}, 1);
    chk({res_hi, res_lo} == {kh, kl} && !ctl_flag, "R8 no load",
        {ctl_flag, res_hi, res_lo}, {1'b0, kh, kl});
    // R11 start ignored while powered down
    bus_wr(2'd0, mk(1, 1, 2'd1, 0, 0));
    @(negedge clk);
    chk(ctl_go == 1'b0, "R11 start unpowered", ctl_go, 0);
    sleep_req = 1'b0;
    @(negedge clk);

    // R8 abort in the same cycle as the final bit
    bus_wr(2'd0, mk(1, 1, 2'd0, 0, 0));
    repeat (10 * DIV0 - 1) @(negedge clk);
    sleep_req = 1'b1;
    @(negedge clk);
    chk({res_hi, res_lo} == {kh, kl} && !ctl_flag && !ctl_go, "R8 abort beats done",
        {ctl_flag, res_hi, res_lo}, {1'b0, kh, kl});
    sleep_req = 1'b0;
    @(negedge clk);

    // R11 start write while busy does not restart
    analog = 10'h081;
    bus_wr(2'd0, mk(1, 1, 2'd0, 1, 0));
    repeat (5) @(negedge clk);
    bus_wr(2'd0, mk(1, 1, 2'd0, 1, 0));
    n = 6;
    while (ctl_go && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(n == 10 * DIV0, "R11 no restart", n, 10 * DIV0);
    chk({res_hi, res_lo} == 16'h0081, "R11 value", {res_hi, res_lo}, 16'h0081);

    // R10 reset during conversion keeps result bytes
    bus_wr(2'd0, mk(0, 0, 2'd0, 0, 0));
    bus_wr(2'd1, 8'h3C);
    bus_wr(2'd2, 8'h96);
    bus_wr(2'd0, mk(1, 0, 2'd2, 0, 0));
    bus_wr(2'd0, mk(1, 1, 2'd2, 0, 0));
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!ctl_go && !ctl_en && !conv_pwr, "R10 reset abort", {ctl_go, ctl_en, conv_pwr}, 0);
    chk({res_hi, res_lo} == 16'h3C96, "R10 result kept", {res_hi, res_lo}, 16'h3C96);
    repeat (30) @(negedge clk);
    chk({res_hi, res_lo} == 16'h3C96 && !ctl_flag, "R10 no late load",
        {ctl_flag, res_hi, res_lo}, 16'h3C96);

    finish_run();
  end
endmodule